// File: doc/BRIEF.md
# Brightness Gamma Table Updater

This block turns a discrete brightness level into the command traffic that reprograms a display controller's gamma curve. A request carries a level from 0 to 10. While the panel is powered, the block streams the 23-byte gamma table for that level from an internal ROM to a downstream command writer. When the table has gone out, it sends a separate two-byte apply sequence so that the controller switches to the new curve.

The downstream writer is driven through a sequence handshake:

- a one-cycle start strobe opens each sequence;
- bytes then follow under a valid/ready pair, with a marker on the first byte;
- the writer closes each sequence with a done pulse and an error flag.

Errors build up across the two sequences of one update. Once an error is recorded, the rest of the update is skipped. When the update ends, the accumulated error goes back to the requester and the record is cleared.

A request that arrives while an update is running is held in a single slot, and a later arrival replaces it. The held request is serviced once the running update has finished.

Top module: `gamma_level_updater`

## Requirements
- R1: After a synchronous reset, `busy`, `seq_start`, `byte_valid`, `byte_first` and `upd_done` are all low.
- R2: A requested level above 10 is treated as level 10.
- R3: For effective level L, the table sequence is 23 bytes. Byte 0 is 0xFA, byte 1 is 0x00, and byte k (2 ≤ k ≤ 22) is ((29·k) mod 256) XOR (11·L).
- R4: After the table sequence has been closed by `wr_done`, a second sequence follows with its own start strobe, made of exactly the bytes 0xFA then 0x01.
- R5: `byte_first` is high on the first byte of each sequence and on no other byte.
- R6: Each sequence is opened by a single-cycle `seq_start`, during which `byte_valid` is low.
- R7: If the writer reports `wr_err` at the end of the table sequence, the apply sequence is not sent, and `upd_err` is 1 when `upd_done` pulses.
- R8: Every update ends with a one-cycle `upd_done` pulse that carries the accumulated error on `upd_err`. The error record is then cleared, so the next update sends both sequences and reports 0.
- R9: A request accepted during an update is serviced after that update finishes. Only the most recent waiting level is kept, including when it arrives in the cycle the previous held request is taken.
- R10: `busy` goes high in the cycle after a request is accepted. It stays high while any byte is offered and falls when the final `upd_done` pulses with nothing waiting.
- R11: While `powered` is low, requests are ignored: no sequence starts, `busy` stays low, and nothing is sent after power returns.
- R12: An offered byte keeps `byte_valid` high and `byte_data` unchanged until `byte_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| powered | input | 1 | Panel supply is up; requests are accepted only while high |
| req_valid | input | 1 | Brightness request strobe |
| req_level | input | 4 | Requested brightness level |
| busy | output | 1 | An update is held or in progress |
| seq_start | output | 1 | One-cycle strobe opening a command sequence |
| byte_valid | output | 1 | A command byte is offered |
| byte_data | output | 8 | Offered command byte |
| byte_first | output | 1 | Offered byte is the first of its sequence |
| byte_ready | input | 1 | Writer accepts the offered byte |
| wr_done | input | 1 | Writer finished the current sequence |
| wr_err | input | 1 | Writer error, qualified by `wr_done` |
| upd_done | output | 1 | One-cycle pulse at the end of an update |
| upd_err | output | 1 | Accumulated error of the finished update |

## Verification
The contested cycle is the one in which the engine takes the held request and, at the same edge, a new request lands in the hold slot. That slot must end up holding the newcomer, not appear empty. The bench provokes this by raising `req_valid` on two consecutive cycles with different levels while the block is idle. It then judges the result by capturing both complete 25-byte streams and comparing each with the level it should carry, in order. A second case overwrites a waiting level while an update is in flight, and checks that only the last one is sent.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int NUM_LEVELS = 11;
  localparam int TBL_LEN    = 23;
  localparam int LVL_W      = 4;
  localparam logic [7:0] CMD_GAMMA = 8'hFA;
  localparam logic [7:0] ARG_LOAD  = 8'h00;
  localparam logic [7:0] ARG_APPLY = 8'h01;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_FETCH, ST_LOAD, ST_SHOW, ST_WAIT, ST_FINISH
  } upd_state_t;

  // Gamma curve content: header bytes then a level-dependent payload.
  function automatic logic [7:0] curve_byte(int lv, int k);
    if (k == 0)      return CMD_GAMMA;
    else if (k == 1) return ARG_LOAD;
    else             return 8'((k * 29) % 256) ^ 8'(lv * 11);
  endfunction
endpackage

// File: rtl/gamma_curve_rom.sv
module gamma_curve_rom #(
  parameter int NUM_LEVELS = gamma_pkg::NUM_LEVELS,
  parameter int TBL_LEN    = gamma_pkg::TBL_LEN,
  localparam int DEPTH     = NUM_LEVELS * TBL_LEN,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        q
);
  logic [7:0] mem [0:DEPTH-1];

  initial begin
    for (int l = 0; l < NUM_LEVELS; l++)
      for (int k = 0; k < TBL_LEN; k++)
        mem[ADDR_W'(l * TBL_LEN + k)] = gamma_pkg::curve_byte(l, k);
  end

  always_ff @(posedge clk) q <= mem[addr];
endmodule

// File: rtl/gamma_req_hold.sv
module gamma_req_hold #(
  parameter int NUM_LEVELS = gamma_pkg::NUM_LEVELS,
  parameter int LVL_W      = gamma_pkg::LVL_W,
  localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(NUM_LEVELS - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             powered,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  input  logic             take,
  output logic             pend_valid,
  output logic [LVL_W-1:0] pend_level
);
  logic [LVL_W-1:0] clamped;
  assign clamped = (req_level > MAX_LVL) ? MAX_LVL : req_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_level <= MAX_LVL;
    end else if (!powered) begin
      pend_valid <= 1'b0;
    end else if (req_valid) begin
      pend_valid <= 1'b1;
      pend_level <= clamped;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end

  AST_LEVEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    pend_valid |-> pend_level <= MAX_LVL); // R2
  AST_NEWEST_KEPT: assert property (@(posedge clk) disable iff (rst)
    (powered && req_valid) |=> pend_valid); // R9
endmodule

// File: rtl/gamma_seq_engine.sv
module gamma_seq_engine
  import gamma_pkg::*;
#(
  parameter int NUM_LEVELS = gamma_pkg::NUM_LEVELS,
  parameter int TBL_LEN    = gamma_pkg::TBL_LEN,
  parameter int LVL_W      = gamma_pkg::LVL_W,
  localparam int ADDR_W    = $clog2(NUM_LEVELS * TBL_LEN),
  localparam int IDX_W     = $clog2(TBL_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [LVL_W-1:0]  go_level,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [7:0]        rom_q,
  output logic              idle,
  output logic              seq_start,
  output logic              byte_valid,
  output logic [7:0]        byte_data,
  output logic              byte_first,
  input  logic              byte_ready,
  input  logic              wr_done,
  input  logic              wr_err,
  output logic              upd_done,
  output logic              upd_err
);
  upd_state_t       state;
  logic             phase;     // 0: table sequence, 1: apply sequence
  logic [IDX_W-1:0] idx;
  logic [LVL_W-1:0] lvl;
  logic             err_acc;
  logic             last_byte;

  assign idle      = (state == ST_IDLE);
  assign rom_addr  = ADDR_W'(lvl) * ADDR_W'(TBL_LEN) + ADDR_W'(idx);
  assign last_byte = phase ? (idx == IDX_W'(1)) : (idx == IDX_W'(TBL_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      phase      <= 1'b0;
      idx        <= '0;
      lvl        <= '0;
      err_acc    <= 1'b0;
      seq_start  <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_first <= 1'b0;
      upd_done   <= 1'b0;
      upd_err    <= 1'b0;
    end else begin
      seq_start <= 1'b0;
      upd_done  <= 1'b0;
      case (state)
        ST_IDLE: if (go) begin
          lvl   <= go_level;
          phase <= 1'b0;
          state <= ST_START;
        end
        ST_START: begin
          if (err_acc) begin
            if (!phase) phase <= 1'b1;
            else        state <= ST_FINISH;
          end else begin
            seq_start <= 1'b1;
            idx       <= '0;
            state     <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_LOAD;
        ST_LOAD: begin
          byte_valid <= 1'b1;
          byte_first <= (idx == '0);
          byte_data  <= !phase ? rom_q : ((idx == '0) ? CMD_GAMMA : ARG_APPLY);
          state      <= ST_SHOW;
        end
        ST_SHOW: if (byte_ready) begin
          byte_valid <= 1'b0;
          byte_first <= 1'b0;
          if (last_byte) state <= ST_WAIT;
          else begin
            idx   <= idx + 1'b1;
            state <= ST_FETCH;
          end
        end
        ST_WAIT: if (wr_done) begin
          err_acc <= err_acc | wr_err;
          if (!phase) begin
            phase <= 1'b1;
            state <= ST_START;
          end else state <= ST_FINISH;
        end
        ST_FINISH: begin
          upd_done <= 1'b1;
          upd_err  <= err_acc;
          err_acc  <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data))); // R12
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    seq_start |=> !seq_start); // R6
  AST_START_NO_BYTE: assert property (@(posedge clk) disable iff (rst)
    seq_start |-> !byte_valid); // R6
  AST_FIRST_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    byte_first |-> byte_valid); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    upd_done |=> !upd_done); // R8
endmodule

// File: rtl/gamma_level_updater.sv
module gamma_level_updater #(
  parameter int NUM_LEVELS = gamma_pkg::NUM_LEVELS,
  parameter int TBL_LEN    = gamma_pkg::TBL_LEN,
  parameter int LVL_W      = gamma_pkg::LVL_W,
  localparam int ADDR_W    = $clog2(NUM_LEVELS * TBL_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             powered,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  output logic             busy,
  output logic             seq_start,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             byte_first,
  input  logic             byte_ready,
  input  logic             wr_done,
  input  logic             wr_err,
  output logic             upd_done,
  output logic             upd_err
);
  logic              pend_valid;
  logic [LVL_W-1:0]  pend_level;
  logic              idle;
  logic              take;
  logic [ADDR_W-1:0] rom_addr;
  logic [7:0]        rom_q;

  assign take = idle & pend_valid & powered;
  assign busy = pend_valid | ~idle;

  gamma_req_hold #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) i_hold (
    .clk(clk), .rst(rst), .powered(powered), .req_valid(req_valid),
    .req_level(req_level), .take(take), .pend_valid(pend_valid),
    .pend_level(pend_level));

  gamma_curve_rom #(.NUM_LEVELS(NUM_LEVELS), .TBL_LEN(TBL_LEN)) i_rom (
    .clk(clk), .addr(rom_addr), .q(rom_q));

  gamma_seq_engine #(.NUM_LEVELS(NUM_LEVELS), .TBL_LEN(TBL_LEN), .LVL_W(LVL_W)) i_eng (
    .clk(clk), .rst(rst), .go(take), .go_level(pend_level),
    .rom_addr(rom_addr), .rom_q(rom_q), .idle(idle),
    .seq_start(seq_start), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_first(byte_first), .byte_ready(byte_ready), .wr_done(wr_done),
    .wr_err(wr_err), .upd_done(upd_done), .upd_err(upd_err));

  AST_BUSY_WHILE_SENDING: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> busy); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (powered && req_valid) |=> busy); // R10
  AST_UNPOWERED_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!powered && idle && !pend_valid) |=> !seq_start); // R11
endmodule

// File: tb/test_gamma_level_updater.sv
module test_gamma_level_updater;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic powered = 1'b1;
  logic req_valid = 1'b0;
  logic [3:0] req_level = '0;
  logic busy, seq_start, byte_valid, byte_first, upd_done, upd_err;
  logic [7:0] byte_data;
  logic byte_ready, wr_done, wr_err;

  always #2.5 clk = ~clk;  // 200 MHz

  gamma_level_updater i_gamma_level_updater (
    .clk(clk), .rst(rst), .powered(powered), .req_valid(req_valid),
    .req_level(req_level), .busy(busy), .seq_start(seq_start),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_first(byte_first),
    .byte_ready(byte_ready), .wr_done(wr_done), .wr_err(wr_err),
    .upd_done(upd_done), .upd_err(upd_err));

  int nchk = 0, nfail = 0;
  logic [7:0] cap [0:63];
  logic       capf [0:63];
  int ncap = 0, nstart = 0, nupd = 0;
  logic last_err = 1'b0;
  logic stall = 1'b0, inject_err = 1'b0;

  // Stimulus/expected vectors: requested level, effective level
  localparam int NVEC = 6;
  localparam int VEC [NVEC][2] = '{'{0,0}, '{5,5}, '{10,10}, '{3,3}, '{15,10}, '{11,10}};

  function automatic logic [7:0] exp_byte(int lv, int i);
    if (i == 0 || i == 23) return 8'hFA;
    if (i == 1)            return 8'h00;
    if (i == 24)           return 8'h01;
    return 8'((i * 29) % 256) ^ 8'(lv * 11);
  endfunction

  // Downstream writer model and monitor
  initial begin
    logic fire = 1'b0;
    int pos = 0, len = 23;
    byte_ready = 1'b0; wr_done = 1'b0; wr_err = 1'b0;
    forever begin
      @(negedge clk);
      wr_done = fire;
      wr_err  = fire & inject_err & (len == 23);
      fire = 1'b0;
      byte_ready = stall ? ~byte_ready : 1'b1;
      if (seq_start) nstart++;
      if (upd_done) begin nupd++; last_err = upd_err; end
      if (byte_valid && byte_ready && !rst) begin
        if (ncap < 64) begin cap[ncap] = byte_data; capf[ncap] = byte_first; end
        ncap++;
        if (byte_first) pos = 0;
        pos++;
        if (pos == 2) len = (byte_data == 8'h01) ? 2 : 23;
        if (pos == len) fire = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon;
    ncap = 0; nstart = 0; nupd = 0;
  endtask

  task automatic send_req(input int lv);
    @(negedge clk); req_valid = 1'b1; req_level = 4'(lv);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic wait_upd(input int n);
    int t = 0;
    while (nupd < n && t < 3000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic check_stream(input int base, input int lv, input string req);
    int bad = -1;
    for (int i = 0; i < 25; i++) begin
      if (cap[base+i] !== exp_byte(lv, i)) begin if (bad < 0) bad = i; end
      if (capf[base+i] !== ((i == 0) || (i == 23))) begin if (bad < 0) bad = 100 + i; end
    end
    if (bad < 0) check(1'b1, req, 0, 0);
    else if (bad >= 100) check(1'b0, {req, " first marker"}, capf[base+bad-100], (bad == 100 || bad == 123));
    else check(1'b0, req, cap[base+bad], exp_byte(lv, bad));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!busy && !seq_start && !byte_valid && !byte_first && !upd_done, "R1 reset during",
          {busy, seq_start, byte_valid, byte_first, upd_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !seq_start && !byte_valid && !upd_done, "R1 reset after",
          {busy, seq_start, byte_valid, upd_done}, 0);

    // Vector walk: R2 clamp, R3 table, R4 apply, R5 markers, R6 starts, R12 stall
    for (int v = 0; v < NVEC; v++) begin
      stall = (v == 3);
      clear_mon();
      send_req(VEC[v][0]);
      check(busy, "R10 busy after accept", busy, 1);
      wait_upd(1);
      check(ncap == 25 && nstart == 2, "R4 R6 byte and start counts", ncap * 16 + nstart, 25 * 16 + 2);
      check_stream(0, VEC[v][1], (VEC[v][0] > 10) ? "R2 clamped stream" : "R3 table stream");
      check(!busy && last_err == 1'b0, "R10 busy falls, R8 no error", {busy, last_err}, 0);
    end
    stall = 1'b0;

    // R7: error on table sequence skips apply
    inject_err = 1'b1;
    clear_mon();
    send_req(5);
    wait_upd(1);
    check(ncap == 23 && nstart == 1, "R7 apply skipped", ncap * 16 + nstart, 23 * 16 + 1);
    check(last_err == 1'b1, "R7 error reported", last_err, 1);
    inject_err = 1'b0;

    // R8: error cleared, next update is complete
    clear_mon();
    send_req(6);
    wait_upd(1);
    check(ncap == 25 && last_err == 1'b0, "R8 error cleared", ncap * 2 + last_err, 50);
    check_stream(0, 6, "R8 stream after error");

    // R9: request lands in the cycle the held one is taken
    clear_mon();
    @(negedge clk); req_valid = 1'b1; req_level = 4'd1;
    @(negedge clk); req_level = 4'd4;
    @(negedge clk); req_valid = 1'b0;
    wait_upd(2);
    check(nupd == 2 && ncap == 50, "R9 collision two updates", nupd * 100 + ncap, 250);
    check_stream(0, 1, "R9 collision first");
    check_stream(25, 4, "R9 collision second");

    // R9: only the newest waiting level is kept
    clear_mon();
    send_req(2);
    repeat (10) @(negedge clk);
    send_req(7);
    repeat (5) @(negedge clk);
    send_req(9);
    wait_upd(2);
    repeat (200) @(negedge clk);
    check(nupd == 2 && nstart == 4, "R9 overwrite count", nupd * 10 + nstart, 24);
    check_stream(25, 9, "R9 newest level");

    // R11: unpowered requests ignored
    clear_mon();
    @(negedge clk); powered = 1'b0;
    send_req(3);
    repeat (40) @(negedge clk);
    check(nstart == 0 && !busy, "R11 unpowered ignored", nstart * 2 + busy, 0);
    powered = 1'b1;
    repeat (40) @(negedge clk);
    check(nstart == 0 && ncap == 0 && !busy, "R11 nothing after power up", nstart + ncap + busy, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule